// File: doc/BRIEF.md
# Timer Output Pulse and Clock Generator

This block turns the single-cycle terminal-count event of a timer core into the level on a timer output pin and a matching status bit. In pulse mode each event starts an active interval whose length, one to four timer clock cycles, comes from a small width field. The interval shortens only on cycles where the timer count enable is high, so when the counter runs from a slow or external clock the pulse follows that clock and not the fast peripheral clock. An invert bit can flip the pulse polarity at the pin.

In clock mode every event flips a toggle register. Events that arrive at a steady period then produce an output with a 50% duty cycle at half the event rate. The status bit always shows the output before polarity inversion, so software can read back the current state. The counter, its period registers and any bus access live outside this block.

Top module: `tmr_out_gen`

## Requirements
- R1: After reset the pulse is inactive and the toggle state is 0, so `status` is 0 and `pin_out` is 0 when `inv_out` is 0.
- R2: `clk_mode` = 0 selects pulse mode and `clk_mode` = 1 selects clock mode. The mode bit is applied combinationally to the outputs.
- R3: In pulse mode a `tc_evt` loads a width of `pw_sel`+1 cycles (00→1, 01→2, 10→3, 11→4). `status` goes high on the clock edge that samples the event and, with `cnt_en` held high, stays high for exactly that many cycles.
- R4: The remaining pulse width decreases only on cycles where `cnt_en` is 1. While `cnt_en` is 0 an active pulse holds its level and its remaining width.
- R5: A `tc_evt` that arrives while a pulse is active reloads the width from the current `pw_sel`, which restarts the pulse.
- R6: In clock mode each `tc_evt` inverts the toggle state on the edge that samples it. With no event the toggle state holds, in either mode.
- R7: In pulse mode `pin_out` is `status` XOR `inv_out`. In clock mode `inv_out` has no effect and `pin_out` equals `status`.
- R8: In clock mode `status` equals the toggle state. In pulse mode `status` is 1 exactly while the pulse is active.
- R9: The width is captured when the event is taken. A change of `pw_sel` during an active pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_evt | input | 1 | Single-cycle terminal-count event from the timer core |
| cnt_en | input | 1 | Timer count enable (one timer clock tick) |
| clk_mode | input | 1 | 0 = pulse mode, 1 = clock (toggle) mode |
| pw_sel | input | PW_BITS | Pulse width code; the width is code + 1 cycles |
| inv_out | input | 1 | Invert the pin level in pulse mode |
| pin_out | output | 1 | Timer output pin level |
| status | output | 1 | Output state before inversion, readable by software |

## Verification
The bench builds the block with the default `PW_BITS` = 2, so all four width codes are tried, and the longest pulse of four cycles sits next to the reload and pause cases. A behavioural model based on integers follows the remaining width and the toggle state on every edge. Sparse count enables show that a pulse stretches to the timer clock. Events during an active pulse and `pw_sel` changes during a pulse cover restart and width capture. A run in clock mode with `inv_out` set shows that the invert bit is ignored there.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;
  // Pulse length in timer ticks for a given width code.
  function automatic int unsigned pulse_len(input int unsigned code);
    return code + 1;
  endfunction

  // Output polarity helper: inversion only applies outside clock mode.
  function automatic logic apply_pol(input logic lvl, input logic inv, input logic clk_mode);
    return clk_mode ? lvl : (lvl ^ inv);
  endfunction
endpackage

// File: rtl/tmr_pulse_stretch.sv
module tmr_pulse_stretch #(
  parameter int PW_BITS = 2,
  localparam int CNT_W  = PW_BITS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic               tick,
  input  logic               clr,
  input  logic [PW_BITS-1:0] width_code,
  output logic               active,
  output logic [CNT_W-1:0]   remain
);
  import tmr_out_pkg::*;

  localparam int MAX_LEN = 1 << PW_BITS;

  logic [CNT_W-1:0] load_val;
  logic             dec_ok;

  assign load_val = CNT_W'(pulse_len(int'(width_code)));
  assign dec_ok   = tick && (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       remain <= '0;
    else if (load_evt)       remain <= load_val;
    else if (dec_ok)         remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !clr) |=> (remain == CNT_W'(int'($past(width_code)) + 1))); // R3

  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_evt && !clr) |=> $stable(remain)); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(remain) <= MAX_LEN); // R3
endmodule

// File: rtl/tmr_clk_toggle.sv
module tmr_clk_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_evt,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (!rst_n)        tog <= 1'b0;
    else if (flip_evt) tog <= ~tog;
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> (tog != $past(tog))); // R6

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_evt |=> $stable(tog)); // R6
endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen #(
  parameter int PW_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tc_evt,
  input  logic               cnt_en,
  input  logic               clk_mode,
  input  logic [PW_BITS-1:0] pw_sel,
  input  logic               inv_out,
  output logic               pin_out,
  output logic               status
);
  import tmr_out_pkg::*;

  localparam int CNT_W = PW_BITS + 1;

  // Named internal events for the assertions.
  logic             pulse_load;
  logic             tog_flip;
  logic             pulse_act;
  logic             tog_q;
  logic [CNT_W-1:0] pulse_rem;

  assign pulse_load = tc_evt && !clk_mode;
  assign tog_flip   = tc_evt && clk_mode;

  tmr_pulse_stretch #(.PW_BITS(PW_BITS)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt   (pulse_load),
    .tick       (cnt_en),
    .clr        (clk_mode),
    .width_code (pw_sel),
    .active     (pulse_act),
    .remain     (pulse_rem)
  );

  tmr_clk_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .flip_evt (tog_flip),
    .tog      (tog_q)
  );

  assign status  = clk_mode ? tog_q : pulse_act;
  assign pin_out = apply_pol(status, inv_out, clk_mode);

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_load |=> (clk_mode || status)); // R3

  AST_STATUS_CLEAR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mode && !tc_evt && cnt_en && pulse_rem == CNT_W'(1)) |=> (clk_mode || !status)); // R8
endmodule

// File: tb/tmr_out_gen_test.sv
module tmr_out_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tc_evt = 1'b0;
  logic       cnt_en = 1'b0;
  logic       clk_mode = 1'b0;
  logic [1:0] pw_sel = 2'b00;
  logic       inv_out = 1'b0;
  logic       pin_out, status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_rem = 0;
  int m_tog = 0;

  always #2.5 clk = ~clk;

  tmr_out_gen #(.PW_BITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .cnt_en(cnt_en),
    .clk_mode(clk_mode), .pw_sel(pw_sel), .inv_out(inv_out),
    .pin_out(pin_out), .status(status)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_tog = 0;
    end else if (clk_mode) begin
      m_rem = 0;
      if (tc_evt) m_tog = 1 - m_tog;
    end else begin
      if (tc_evt) m_rem = int'(pw_sel) + 1;
      else if (cnt_en && m_rem > 0) m_rem = m_rem - 1;
    end
  end

  task automatic compare();
    logic e_st, e_pin;
    e_st  = clk_mode ? (m_tog != 0) : (m_rem > 0);
    e_pin = clk_mode ? e_st : (e_st ^ inv_out);
    checks++;
    if (status !== e_st) begin
      errors++;
      $display("FAIL %s status actual=%b expected=%b", tag, status, e_st);
    end
    checks++;
    if (pin_out !== e_pin) begin
      errors++;
      $display("FAIL %s pin_out actual=%b expected=%b", tag, pin_out, e_pin);
    end
  endtask

  // one cycle: check outputs at negedge, then drive the next inputs
  task automatic step(input logic ev, input logic en, input logic md,
                      input logic [1:0] pw, input logic inv);
    @(negedge clk);
    compare();
    tc_evt = ev; cnt_en = en; clk_mode = md; pw_sel = pw; inv_out = inv;
  endtask

  task automatic idle(input int n, input logic en, input logic md,
                      input logic [1:0] pw, input logic inv);
    for (int i = 0; i < n; i++) step(1'b0, en, md, pw, inv);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(2, 1'b1, 1'b0, 2'b00, 1'b0);

    // R3: every width code, enable held high
    tag = "R3";
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 1'b1, 1'b0, 2'(c), 1'b0);
      idle(6, 1'b1, 1'b0, 2'(c), 1'b0);
    end

    // R4: sparse enable stretches the pulse
    tag = "R4";
    step(1'b1, 1'b0, 1'b0, 2'b11, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b0, (i % 3) == 2, 1'b0, 2'b11, 1'b0);

    // R5: retrigger during active pulse
    tag = "R5";
    step(1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
    idle(1, 1'b1, 1'b0, 2'b10, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b01, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 1'b0);
    idle(6, 1'b1, 1'b0, 2'b11, 1'b0);

    // R9: width code changes mid-pulse
    tag = "R9";
    step(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    idle(6, 1'b1, 1'b0, 2'b11, 1'b0);

    // R7: inverted pulse
    tag = "R7";
    step(1'b1, 1'b1, 1'b0, 2'b01, 1'b1);
    idle(5, 1'b1, 1'b0, 2'b01, 1'b1);

    // R6/R8: clock mode toggling, invert ignored
    tag = "R6";
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
      idle(3, 1'b1, 1'b1, 2'b00, 1'b0);
    end
    tag = "R8";
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 1'b1, 2'b10, 1'b1);
      idle(2, 1'b0, 1'b1, 2'b10, 1'b1);
    end

    // R2: mode switching, pulse cut by clock mode, toggle held in pulse mode
    tag = "R2";
    step(1'b1, 1'b1, 1'b0, 2'b11, 1'b0);
    idle(1, 1'b1, 1'b1, 2'b11, 1'b0);
    idle(2, 1'b1, 1'b0, 2'b11, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
    idle(3, 1'b1, 1'b1, 2'b00, 1'b1);
    idle(2, 1'b1, 1'b0, 2'b00, 1'b0);
    @(negedge clk);
    compare();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule